// File: doc/BRIEF.md
# Sparse Power-Management Register Bank

This block holds the 32-bit control and status registers of a power-management unit. They sit behind a simple single-cycle register bus. The 14-bit byte address covers a window from 0x0000 to 0x3D0B. Only a sparse set of word offsets inside that window decodes to real storage. Each defined register is plain read/write storage and loads its own constant at reset. Offsets that decode to nothing return zero on read and ignore writes.

One register has a side effect. The power-hold control register sits at offset 0x330C. Bit 8 of that register drives the `power_hold` output, and the bit is set at reset, so the system stays powered. When software writes that register with bit 8 clear, the block raises a one-cycle `shutdown_req` pulse. The sequencing of power domains, clocks and pads happens elsewhere. Every other register only stores what software puts into it.

Top module: `pwr_regbank`

## Requirements
- R1: On reset every defined register loads its own value. Offset 0x0200 loads 0x00010000. Offset 0x330C loads 0x00005300. The 32 registers at 0x1100..0x117C load 0xFFFFFFFF. The eight domain registers at 0x3C00 + n*0x20 load 0x00000007. Offset 0x3D08 loads 0x00000001. The eight scratch registers at 0x0800..0x081C load zero.
- R2: A write to a defined register stores all 32 bits exactly as written, with no masking, and a later read returns them.
- R3: `rdata` is registered. It shows the addressed value one cycle after a cycle with `re` high, and it holds its last value in cycles with `re` low.
- R4: A read of an aligned offset inside the window that matches no defined register returns zero.
- R5: A write to an offset that matches no defined register is discarded. Reading that offset still returns zero, and the neighbouring defined registers keep their contents.
- R6: An access with address bits [1:0] not zero is unsupported and is treated as unmapped. Such a read returns zero, and such a write changes no register.
- R7: Offset 0x3D08 is the last defined register. Offsets from 0x3D0C upward are unmapped.
- R8: A write to offset 0x330C with bit 8 clear raises `shutdown_req` for exactly the following cycle. A repeated such write pulses again. A write to 0x330C with bit 8 set raises no pulse, and neither does a write with bit 8 clear to any other offset.
- R9: `power_hold` equals bit 8 of the register at 0x330C. It is high after reset and follows each write to that register from the next cycle.
- R10: A read and a write to the same register in the same cycle return the old value. The new value is returned by the next read.
- R11: Decode compares the full word offset, so the eight scratch registers at 0x0800..0x081C (4-byte spacing) are distinct and do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 14 | Byte address of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle power-off request pulse |
| power_hold | output | 1 | Current value of the power-hold bit |

## Verification
Two functions can fall in the same cycle: a read and a write share one address. The bench provokes this by raising `we` and `re` together on a scratch register that holds a known value. It then expects the old contents in `rdata` on the next cycle and the new contents on the following read. A second collision is a hold-register write that clears bit 8. In that case the shutdown pulse and the fall of `power_hold` appear in the same cycle, and both are sampled there.

// File: rtl/pwr_regbank_pkg.sv
package pwr_regbank_pkg;

    localparam int ADDR_W   = 14;
    localparam int DATA_W   = 32;
    localparam int NUM_GRP  = 10;
    localparam int HOLD_GRP = 7;
    localparam int HOLD_BIT = 8;

    // Register groups: base byte offset, entry count, log2 of stride, reset value.
    function automatic int grp_base(input int g);
        case (g)
            0: return 'h0000;
            1: return 'h0200;
            2: return 'h0208;
            3: return 'h0600;
            4: return 'h0700;
            5: return 'h0800;
            6: return 'h1100;
            7: return 'h330C;
            8: return 'h3C00;
            9: return 'h3D08;
            default: return 0;
        endcase
    endfunction

    function automatic int grp_count(input int g);
        case (g)
            3: return 3;
            4: return 9;
            5: return 8;
            6: return 32;
            8: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int grp_shift(input int g);
        case (g)
            8: return 5;
            default: return 2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] grp_rst(input int g);
        case (g)
            1: return 32'h0001_0000;
            2: return 32'h0303_0000;
            6: return 32'hFFFF_FFFF;
            7: return 32'h0000_5300;
            8: return 32'h0000_0007;
            9: return 32'h0000_0001;
            default: return 32'h0;
        endcase
    endfunction

    // Flat index of the first register of group g.
    function automatic int grp_first(input int g);
        int acc;
        acc = 0;
        for (int j = 0; j < g; j++) acc += grp_count(j);
        return acc;
    endfunction

    localparam int NUM_REGS = grp_first(NUM_GRP);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int HOLD_IDX = grp_first(HOLD_GRP);

    function automatic logic [DATA_W-1:0] reg_rst(input int r);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int g = 0; g < NUM_GRP; g++)
            if (r >= grp_first(g) && r < grp_first(g) + grp_count(g)) v = grp_rst(g);
        return v;
    endfunction

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_t;

endpackage

// File: rtl/pwr_regbank_decode.sv
module pwr_regbank_decode
    import pwr_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [NUM_GRP-1:0] hit_v;
    logic [IDX_W-1:0]   idx_v [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int BASE  = grp_base(g);
        localparam int CNT   = grp_count(g);
        localparam int SH    = grp_shift(g);
        localparam int FIRST = grp_first(g);
        localparam logic [ADDR_W:0] BASE_V = (ADDR_W+1)'(BASE);
        localparam logic [ADDR_W:0] SPAN_V = (ADDR_W+1)'(CNT << SH);

        logic [ADDR_W:0] rel;
        assign rel = {1'b0, addr} - BASE_V;

        assign hit_v[g] = ({1'b0, addr} >= BASE_V) && (rel < SPAN_V)
                        && (rel[SH-1:0] == '0) && (addr[1:0] == 2'b00);
        assign idx_v[g] = IDX_W'(FIRST) + IDX_W'(rel >> SH);
    end

    always_comb begin
        dec = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (hit_v[g]) begin
                dec.hit = 1'b1;
                dec.idx = dec.idx | idx_v[g];
            end
        end
    end

    // R11: groups never overlap, so at most one group claims an address.
    a_r11_single_group: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_v));

    // R6: a misaligned address never decodes to storage.
    a_r6_misaligned_miss: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] != 2'b00) |-> !dec.hit);

endmodule

// File: rtl/pwr_regbank_store.sv
module pwr_regbank_store
    import pwr_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_t               wr,
    output logic [DATA_W-1:0] regs [NUM_REGS]
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_V = reg_rst(r);

        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= RST_V;
            else if (wr.en && wr.idx == IDX_W'(r))
                regs[r] <= wr.data;
        end

        // R5: a register changes only through a decoded write to its own index.
        a_r5_no_stray_write: assert property (@(posedge clk) disable iff (rst)
            !(wr.en && wr.idx == IDX_W'(r)) |=> $stable(regs[r]));
    end

endmodule

// File: rtl/pwr_regbank_hold.sv
module pwr_regbank_hold
    import pwr_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  wr_t  wr,
    input  logic hold_bit,
    output logic shutdown_req,
    output logic power_hold
);
    logic hold_wr;
    assign hold_wr = wr.en && (wr.idx == IDX_W'(HOLD_IDX));

    always_ff @(posedge clk) begin
        if (rst) shutdown_req <= 1'b0;
        else     shutdown_req <= hold_wr && !wr.data[HOLD_BIT];
    end

    assign power_hold = hold_bit;

    // R8: a shutdown pulse always coincides with the stored bit being clear.
    a_r8_pulse_with_low_hold: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> !power_hold);

    // R9: power_hold moves only after a write to the hold register.
    a_r9_hold_moves_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(power_hold) |-> $past(hold_wr));

endmodule

// File: rtl/pwr_regbank.sv
module pwr_regbank
    import pwr_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic              shutdown_req,
    output logic              power_hold
);
    dec_t              dec;
    wr_t               wr;
    logic [DATA_W-1:0] regs [NUM_REGS];

    pwr_regbank_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .dec  (dec)
    );

    assign wr.en   = we && dec.hit;
    assign wr.idx  = dec.idx;
    assign wr.data = wdata;

    pwr_regbank_store u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs)
    );

    pwr_regbank_hold u_hold (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .hold_bit     (regs[HOLD_IDX][HOLD_BIT]),
        .shutdown_req (shutdown_req),
        .power_hold   (power_hold)
    );

    // Read port: the value before any same-cycle write is captured.
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= dec.hit ? regs[dec.idx] : '0;
    end

    // R4: a read that decodes to nothing returns zero.
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        $past(re && !dec.hit) |-> (rdata == '0));

    // R3: read data holds while no read is issued.
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(re) |-> $stable(rdata));

endmodule

// File: tb/pwr_regbank_bench.sv
`timescale 1ns/1ps
module pwr_regbank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] addr;
    logic [31:0] wdata;
    logic        we;
    logic        re;
    logic [31:0] rdata;
    logic        shutdown_req;
    logic        power_hold;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwr_regbank u_pwr_regbank (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .wdata        (wdata),
        .we           (we),
        .re           (re),
        .rdata        (rdata),
        .shutdown_req (shutdown_req),
        .power_hold   (power_hold)
    );

    typedef struct packed {
        logic        we;
        logic        re;
        logic        chk;
        logic [13:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 14'h0200, 32'h0, 32'h0001_0000, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h330C, 32'h0, 32'h0000_5300, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h1100, 32'h0, 32'hFFFF_FFFF, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h117C, 32'h0, 32'hFFFF_FFFF, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h3C00, 32'h0, 32'h0000_0007, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h3CE0, 32'h0, 32'h0000_0007, 8'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 14'h3D08, 32'h0, 32'h0000_0001, 8'd7},  // R7
        '{1'b0, 1'b1, 1'b1, 14'h0814, 32'h0, 32'h0000_0000, 8'd1},  // R1
        '{1'b1, 1'b0, 1'b0, 14'h0800, 32'hA5A5_0001, 32'h0, 8'd11},
        '{1'b1, 1'b0, 1'b0, 14'h081C, 32'h5A5A_0008, 32'h0, 8'd11},
        '{1'b0, 1'b1, 1'b1, 14'h0800, 32'h0, 32'hA5A5_0001, 8'd11}, // R11
        '{1'b0, 1'b1, 1'b1, 14'h081C, 32'h0, 32'h5A5A_0008, 8'd11}, // R11
        '{1'b0, 1'b1, 1'b1, 14'h0804, 32'h0, 32'h0000_0000, 8'd11}, // R11
        '{1'b1, 1'b0, 1'b0, 14'h0704, 32'hDEAD_BEEF, 32'h0, 8'd2},
        '{1'b0, 1'b1, 1'b1, 14'h0704, 32'h0, 32'hDEAD_BEEF, 8'd2},  // R2
        '{1'b0, 1'b1, 1'b1, 14'h0100, 32'h0, 32'h0000_0000, 8'd4},  // R4
        '{1'b0, 1'b1, 1'b1, 14'h3D0C, 32'h0, 32'h0000_0000, 8'd7},  // R7
        '{1'b1, 1'b0, 1'b0, 14'h0820, 32'h1234_5678, 32'h0, 8'd5},
        '{1'b0, 1'b1, 1'b1, 14'h0820, 32'h0, 32'h0000_0000, 8'd5},  // R5
        '{1'b0, 1'b1, 1'b1, 14'h081C, 32'h0, 32'h5A5A_0008, 8'd5},  // R5
        '{1'b1, 1'b0, 1'b0, 14'h0802, 32'hFFFF_FFFF, 32'h0, 8'd6},
        '{1'b0, 1'b1, 1'b1, 14'h0800, 32'h0, 32'hA5A5_0001, 8'd6},  // R6
        '{1'b0, 1'b1, 1'b1, 14'h0801, 32'h0, 32'h0000_0000, 8'd6}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle at a falling edge; return at the next falling edge.
    task automatic step(input logic w, input logic r, input logic [13:0] a, input logic [31:0] d);
        we = w; re = r; addr = a; wdata = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", rdata, 32'h0);
        check("R9 power_hold after reset", {31'b0, power_hold}, 32'h1);
        check("R8 no pulse after reset", {31'b0, shutdown_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].we, VECS[i].re, VECS[i].addr, VECS[i].wdata);
            if (VECS[i].chk)
                check($sformatf("R%0d table entry %0d", VECS[i].req, i), rdata, VECS[i].exp);
        end

        // R3: rdata holds while re is low, even when other registers are written
        step(1'b0, 1'b1, 14'h0704, 32'h0);
        step(1'b1, 1'b0, 14'h0708, 32'h0BAD_F00D);
        check("R3 hold during write", rdata, 32'hDEAD_BEEF);
        step(1'b0, 1'b0, 14'h0200, 32'h0);
        check("R3 hold while idle", rdata, 32'hDEAD_BEEF);

        // R10: a read and a write on one address in the same cycle
        step(1'b1, 1'b1, 14'h0808, 32'h1111_2222);
        check("R10 old value on collision", rdata, 32'h0);
        step(1'b0, 1'b1, 14'h0808, 32'h0);
        check("R10 new value next read", rdata, 32'h1111_2222);

        // R8 / R9: power-hold behaviour
        step(1'b1, 1'b0, 14'h330C, 32'h0000_5300);
        check("R8 no pulse with bit 8 set", {31'b0, shutdown_req}, 32'h0);
        check("R9 hold stays high", {31'b0, power_hold}, 32'h1);
        step(1'b1, 1'b0, 14'h0810, 32'h0);
        check("R8 no pulse on other offset", {31'b0, shutdown_req}, 32'h0);
        step(1'b1, 1'b0, 14'h330C, 32'h0000_5200);
        check("R8 pulse on clear", {31'b0, shutdown_req}, 32'h1);
        check("R9 hold falls", {31'b0, power_hold}, 32'h0);
        step(1'b0, 1'b0, 14'h0000, 32'h0);
        check("R8 pulse lasts one cycle", {31'b0, shutdown_req}, 32'h0);
        step(1'b1, 1'b0, 14'h330C, 32'h0);
        check("R8 repeated pulse", {31'b0, shutdown_req}, 32'h1);
        step(1'b0, 1'b1, 14'h330C, 32'h0);
        check("R8 second pulse ends", {31'b0, shutdown_req}, 32'h0);
        check("R2 hold register readback", rdata, 32'h0);
        step(1'b1, 1'b0, 14'h330C, 32'h0000_0100);
        check("R9 hold rises", {31'b0, power_hold}, 32'h1);
        check("R8 no pulse on set", {31'b0, shutdown_req}, 32'h0);

        // R1: a second reset restores the reset values
        rst = 1'b1;
        step(1'b0, 1'b0, 14'h0000, 32'h0);
        rst = 1'b0;
        step(1'b0, 1'b1, 14'h0800, 32'h0);
        check("R1 scratch cleared by reset", rdata, 32'h0);
        step(1'b0, 1'b1, 14'h0704, 32'h0);
        check("R1 control cleared by reset", rdata, 32'h0);
        step(1'b0, 1'b0, 14'h0000, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule